// File: doc/BRIEF.md
# DRAM Power-Up and Refresh Engine

This block brings an EDO DRAM bank out of power-up and then keeps it refreshed. After reset it waits out a long settling pause. It then runs a burst of CAS-before-RAS refresh cycles and raises a ready flag. From then on a free-running interval timer adds one refresh to a pending count every interval. The engine works through that count one refresh at a time whenever it holds the strobe pins.

The RAS, CAS and WE pins are shared with an access sequencer. The engine asks for them with `req_o`. It starts a refresh only on a cycle where `gnt_i` is high, and it flags with `own_o` the cycles in which it drives them. Refreshes may be postponed while the sequencer keeps the pins. When the pending count reaches its limit, `urgent_o` tells the arbiter to give the engine top priority.

No address is driven, because the DRAM takes its row from an internal counter during this kind of refresh. All timing limits are parameters counted in clock cycles. The defaults suit a 100 MHz clock: a 200 µs pause and a 15.6 µs refresh interval.

Top module: `dram_rfsh_eng`

## Requirements
- R1: While `rst_ni` is low, `ras_n_o`, `cas_n_o` and `we_n_o` are 1, and `ready_o`, `req_o`, `own_o` and `pend_o` are 0. This holds at once, without waiting for a clock edge.
- R2: For at least `PAUSE_CYC` cycles after reset is released, the engine neither requests nor owns the pins.
- R3: `ready_o` rises only after exactly `INIT_CBR` refresh cycles (RAS falling edges) have completed since reset, and no earlier.
- R4: Every RAS falling edge happens while CAS is low, and CAS has then been low for at least `CSR_CYC` cycles. RAS never falls with CAS high.
- R5: After RAS falls, CAS stays low for at least `CHR_CYC` cycles.
- R6: RAS stays low for at least `RAS_CYC` cycles per refresh. Between refreshes it stays high for at least `RP_CYC` cycles.
- R7: `we_n_o` is 1 on every cycle, including each RAS falling edge.
- R8: `own_o` rises only in the cycle after one in which `gnt_i` was high. Strobe edges occur only while `own_o` is high.
- R9: `pend_o` stays 0 until `ready_o` is high. After that it gains one every `IVL_CYC` cycles and loses one for each completed refresh.
- R10: `pend_o` saturates at `MAX_PEND`. `urgent_o` is 1 exactly when `pend_o` equals `MAX_PEND`.
- R11: `req_o` is 1 whenever `pend_o` is nonzero, and during the whole initialization burst.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gnt_i | input | 1 | Pin grant from the arbiter; must stay high while `own_o` is high |
| req_o | output | 1 | Request for the shared strobe pins |
| urgent_o | output | 1 | Pending count saturated; request needs top priority |
| own_o | output | 1 | Engine is driving the strobes this cycle |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, held high |
| ready_o | output | 1 | Initialization complete |
| pend_o | output | $clog2(MAX_PEND+1) | Number of postponed refreshes |

## Verification
Assertions check the following on every cycle:
- RAS never falls with CAS high.
- Ownership begins only after a grant.
- The pending count stays within its limit and steps by at most one.
- A nonzero count always raises a request.

The bench's scenarios cover what needs a window of cycles to show:
- The length of the power-up pause and the number of refreshes in the initialization burst.
- The minimum widths of each strobe phase.
- The exact pending count after the bus has been held busy for a chosen number of intervals, including saturation.
- That the count drains once the bus is released.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;
  typedef enum logic [1:0] {PH_PAUSE, PH_INIT, PH_RUN} eng_phase_e;
  typedef enum logic [2:0] {SQ_IDLE, SQ_CSR, SQ_CHR, SQ_RAS, SQ_RP} seq_state_e;
endpackage

// File: rtl/rfsh_cyc_timer.sv
module rfsh_cyc_timer #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned W = $clog2(LIMIT + 1);

  logic [W-1:0] cnt_q;
  logic         wrap;

  assign wrap   = (cnt_q == W'(LIMIT - 1));
  assign tick_o = en_i & wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!en_i)   cnt_q <= '0;
    else if (wrap)    cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  // R9
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < W'(LIMIT));
endmodule

// File: rtl/rfsh_pend_ctr.sv
module rfsh_pend_ctr #(
  parameter int unsigned MAX_PEND = 8,
  localparam int unsigned PW = $clog2(MAX_PEND + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  input  logic          dec_i,
  output logic [PW-1:0] cnt_o,
  output logic          full_o
);
  logic [PW-1:0] cnt_q;

  assign cnt_o  = cnt_q;
  assign full_o = (cnt_q == PW'(MAX_PEND));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (inc_i && !dec_i && !full_o)      cnt_q <= cnt_q + 1'b1;
    else if (dec_i && !inc_i && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  // R10
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= PW'(MAX_PEND));
  // R9
  unit_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1) ||
    (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/rfsh_cbr_seq.sv
module rfsh_cbr_seq
  import dram_rfsh_pkg::*;
#(
  parameter int unsigned CSR_CYC = 2,
  parameter int unsigned CHR_CYC = 2,
  parameter int unsigned RAS_CYC = 6,
  parameter int unsigned RP_CYC  = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic idle_o,
  output logic done_o,
  output logic own_o,
  output logic ras_n_o,
  output logic cas_n_o,
  output logic we_n_o
);
  localparam int unsigned RAS_TAIL = RAS_CYC - CHR_CYC;
  localparam int unsigned M1 = (CSR_CYC > CHR_CYC) ? CSR_CYC : CHR_CYC;
  localparam int unsigned M2 = (RAS_TAIL > RP_CYC) ? RAS_TAIL : RP_CYC;
  localparam int unsigned MAXP = (M1 > M2) ? M1 : M2;
  localparam int unsigned CW = $clog2(MAXP + 1);

  seq_state_e   st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          last;

  assign last = (cnt_q == '0);

  always_comb begin
    st_d  = st_q;
    cnt_d = last ? cnt_q : cnt_q - 1'b1;
    unique case (st_q)
      SQ_IDLE: if (start_i) begin st_d = SQ_CSR; cnt_d = CW'(CSR_CYC - 1);  end
      SQ_CSR:  if (last)    begin st_d = SQ_CHR; cnt_d = CW'(CHR_CYC - 1);  end
      SQ_CHR:  if (last)    begin st_d = SQ_RAS; cnt_d = CW'(RAS_TAIL - 1); end
      SQ_RAS:  if (last)    begin st_d = SQ_RP;  cnt_d = CW'(RP_CYC - 1);   end
      SQ_RP:   if (last)    begin st_d = SQ_IDLE; cnt_d = '0;               end
      default:              begin st_d = SQ_IDLE; cnt_d = '0;               end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= SQ_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign idle_o  = (st_q == SQ_IDLE);
  assign done_o  = (st_q == SQ_RP) && last;
  assign own_o   = !idle_o;
  assign cas_n_o = !((st_q == SQ_CSR) || (st_q == SQ_CHR));
  assign ras_n_o = !((st_q == SQ_CHR) || (st_q == SQ_RAS));
  assign we_n_o  = 1'b1;

  // R4
  cas_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_n_o) |-> !cas_n_o && $past(!cas_n_o));
  // R6
  rp_after_ras_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ras_n_o) |-> (st_q == SQ_RP));
endmodule

// File: rtl/dram_rfsh_eng.sv
module dram_rfsh_eng
  import dram_rfsh_pkg::*;
#(
  parameter int unsigned PAUSE_CYC = 20000,
  parameter int unsigned INIT_CBR  = 8,
  parameter int unsigned IVL_CYC   = 1560,
  parameter int unsigned MAX_PEND  = 8,
  parameter int unsigned CSR_CYC   = 2,
  parameter int unsigned CHR_CYC   = 2,
  parameter int unsigned RAS_CYC   = 6,
  parameter int unsigned RP_CYC    = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic gnt_i,
  output logic req_o,
  output logic urgent_o,
  output logic own_o,
  output logic ras_n_o,
  output logic cas_n_o,
  output logic we_n_o,
  output logic ready_o,
  output logic [$clog2(MAX_PEND+1)-1:0] pend_o
);
  localparam int unsigned IW = $clog2(INIT_CBR + 1);

  eng_phase_e    ph_q;
  logic [IW-1:0] init_cnt_q;
  logic          pause_tick, ivl_tick;
  logic          seq_idle, seq_done, start, want;
  logic          pend_full;

  rfsh_cyc_timer #(.LIMIT(PAUSE_CYC)) u_pause (
    .clk_i, .rst_ni, .en_i(ph_q == PH_PAUSE), .tick_o(pause_tick));

  rfsh_cyc_timer #(.LIMIT(IVL_CYC)) u_ivl (
    .clk_i, .rst_ni, .en_i(ph_q == PH_RUN), .tick_o(ivl_tick));

  rfsh_pend_ctr #(.MAX_PEND(MAX_PEND)) u_pend (
    .clk_i, .rst_ni,
    .inc_i(ivl_tick),
    .dec_i(seq_done && ph_q == PH_RUN),
    .cnt_o(pend_o),
    .full_o(pend_full));

  rfsh_cbr_seq #(
    .CSR_CYC(CSR_CYC), .CHR_CYC(CHR_CYC), .RAS_CYC(RAS_CYC), .RP_CYC(RP_CYC)
  ) u_seq (
    .clk_i, .rst_ni, .start_i(start),
    .idle_o(seq_idle), .done_o(seq_done), .own_o(own_o),
    .ras_n_o(ras_n_o), .cas_n_o(cas_n_o), .we_n_o(we_n_o));

  always_comb begin
    unique case (ph_q)
      PH_INIT: want = 1'b1;
      PH_RUN:  want = (pend_o != '0);
      default: want = 1'b0;
    endcase
  end

  assign start    = want && gnt_i && seq_idle;
  assign req_o    = want || own_o;
  assign urgent_o = pend_full;
  assign ready_o  = (ph_q == PH_RUN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q       <= PH_PAUSE;
      init_cnt_q <= '0;
    end else begin
      unique case (ph_q)
        PH_PAUSE: if (pause_tick) ph_q <= PH_INIT;
        PH_INIT:  if (seq_done) begin
          if (init_cnt_q == IW'(INIT_CBR - 1)) ph_q <= PH_RUN;
          else init_cnt_q <= init_cnt_q + 1'b1;
        end
        default: ;
      endcase
    end
  end

  // R8
  own_after_gnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(own_o) |-> $past(gnt_i));
  // R11
  pend_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_o != '0) |-> req_o);
  // R3
  ready_burst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> $past(seq_done) && $past(init_cnt_q) == IW'(INIT_CBR - 1));
  // R9
  idle_before_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> pend_o == '0);
endmodule

// File: tb/dram_rfsh_eng_tb.sv
module dram_rfsh_eng_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PAUSE = 20, INIT = 8, IVL = 40, MAXP = 8;
  localparam int CSR = 2, CHR = 2, RAS = 5, RP = 3;
  localparam int PW = $clog2(MAXP + 1);
  // busy intervals, expected pending count at end of window
  localparam int VEC [4][2] = '{'{1, 1}, '{3, 3}, '{8, 8}, '{12, 8}};

  logic clk = 1'b0, rst_n = 1'b0, busy = 1'b0;
  logic req, urgent, own, ras_n, cas_n, we_n, ready, gnt;
  logic [PW-1:0] pend;
  int n_chk = 0, n_fail = 0, cyc = 0, falls = 0;
  int cas_lo_run = 0, ras_lo_run = 0, ras_hi_run = 1000;
  logic prev_ras = 1'b1, prev_cas = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign gnt = req && (own || !busy);

  dram_rfsh_eng #(
    .PAUSE_CYC(PAUSE), .INIT_CBR(INIT), .IVL_CYC(IVL), .MAX_PEND(MAXP),
    .CSR_CYC(CSR), .CHR_CYC(CHR), .RAS_CYC(RAS), .RP_CYC(RP)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .gnt_i(gnt), .req_o(req), .urgent_o(urgent),
    .own_o(own), .ras_n_o(ras_n), .cas_n_o(cas_n), .we_n_o(we_n),
    .ready_o(ready), .pend_o(pend));

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      chk(0, "watchdog", cyc, 0);
      finish_run();
    end
  end

  // strobe timing monitor
  always @(negedge clk) begin
    if (!rst_n) begin
      prev_ras = 1'b1; prev_cas = 1'b1;
      cas_lo_run = 0; ras_lo_run = 0; ras_hi_run = 1000;
    end else begin
      if (prev_ras && !ras_n) begin
        falls++;
        chk(!cas_n && cas_lo_run >= CSR, "R4 cas-low cycles before ras fall", cas_lo_run, CSR);
        chk(ras_hi_run >= RP, "R6 ras precharge cycles", ras_hi_run, RP);
        chk(we_n == 1'b1, "R7 we high at ras fall", we_n, 1);
        chk(own, "R8 own during strobe", own, 1);
        if (!ready) chk(pend == 0, "R9 pend zero before ready", pend, 0);
      end
      if (!prev_ras && ras_n)
        chk(ras_lo_run >= RAS, "R6 ras low cycles", ras_lo_run, RAS);
      if (!prev_cas && cas_n && !ras_n)
        chk(ras_lo_run >= CHR, "R5 cas hold after ras fall", ras_lo_run, CHR);
      if (!prev_cas && cas_n && ras_n)
        chk(0, "R4 cas rose without ras fall", 0, 1);
      cas_lo_run = cas_n ? 0 : cas_lo_run + 1;
      ras_lo_run = ras_n ? 0 : ras_lo_run + 1;
      ras_hi_run = ras_n ? ras_hi_run + 1 : 0;
      prev_ras = ras_n; prev_cas = cas_n;
    end
  end

  task automatic wait_quiet();
    while (!(pend == 0 && !own)) @(negedge clk);
  endtask

  initial begin
    int f0, t0;
    repeat (4) @(negedge clk);
    // R1
    chk(ras_n && cas_n && we_n, "R1 strobes high in reset", {ras_n, cas_n, we_n}, 7);
    chk(!ready && !req && !own && pend == 0, "R1 flags low in reset",
        {ready, req, own}, 0);
    rst_n = 1'b1;
    // R2
    begin
      bit quiet = 1'b1;
      for (int i = 0; i < PAUSE - 1; i++) begin
        @(negedge clk);
        if (req || own || !ras_n || !cas_n) quiet = 1'b0;
      end
      chk(quiet, "R2 no activity during pause", quiet, 1);
    end
    // R3, R11
    @(negedge clk); @(negedge clk);
    chk(req, "R11 request during init", req, 1);
    while (!ready) @(negedge clk);
    chk(falls == INIT, "R3 init refresh count at ready", falls, INIT);
    // R9 interval
    wait_quiet();
    t0 = cyc;
    while (pend == 0) @(negedge clk);
    chk(cyc - t0 <= IVL, "R9 tick within interval", cyc - t0, IVL);
    f0 = falls;
    wait_quiet();
    chk(falls == f0 + 1, "R9 pending refresh served", falls - f0, 1);
    // table: hold the bus busy for k intervals
    for (int v = 0; v < 4; v++) begin
      wait_quiet();
      busy = 1'b1;
      repeat (VEC[v][0] * IVL) @(negedge clk);
      chk(pend == VEC[v][1], "R9/R10 pending after busy window", pend, VEC[v][1]);
      chk(urgent == (VEC[v][1] == MAXP), "R10 urgent flag", urgent, VEC[v][1] == MAXP);
      chk(req, "R11 request while pending", req, 1);
      chk(!own && ras_n && cas_n, "R8 no strobes without grant", own, 0);
      f0 = falls;
      busy = 1'b0;
      wait_quiet();
      chk(falls - f0 >= VEC[v][1], "R9 drained refreshes", falls - f0, VEC[v][1]);
    end
    // R1 async reset while owning
    wait_quiet();
    while (!own || ras_n) @(negedge clk);
    #1 rst_n = 1'b0;
    #1 chk(ras_n && cas_n && !own && !ready && pend == 0, "R1 async reset mid-refresh",
           {ras_n, cas_n, own, ready}, 12);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule